// File: doc/BRIEF.md
# Serial-Commanded Open-Drain Relay Bank Driver

This block turns a three-wire serial command stream (a bit clock, a data line and a frame strobe) into 64 open-drain relay driver controls. Each command frame carries a bank number and one byte of channel data. The bits are collected in a holding shift register. Only when the strobe marks the end of the frame is the bank number decoded and the byte copied into that bank's register. All three serial wires are asynchronous to the system clock. They pass through two-flop synchronizers and are edge-detected before any use.

Each channel has its own pin enable. A channel that is off pulls its pin to ground. A channel that is on releases its pin, so an external pull-up can turn on the driver transistor. The block has no way to drive a pin high. The commanded state of all 64 channels can also be read back on a status bus. This lets a host or a bench see the command separately from the pin enables.

Top module: `relay_bank_ctrl`

## Requirements
- R1: There are 64 channels in 8 banks of 8. Data bit i of a frame sent to bank b sets channel b*8+i. Channel c is `bank_state[c]` and `pin_pull_low[c]`.
- R2: A frame is 11 bits sampled on rising edges of `ser_clk`, most significant bit first. The first three bits are the bank number (bit 2 first). The next eight are the data byte (bit 7 first).
- R3: A bank register is written only on the rising edge of `ser_stb`. While bits are still being shifted, no bank changes. The new value appears on `bank_state` within 4 `clk` cycles after the strobe rises at the pin.
- R4: Each accepted frame changes exactly one bank. The other seven banks keep their values.
- R5: `pin_pull_low[c]` is 1 (pin driven to 0) when channel c is off, and 0 (pin released, high impedance) when channel c is on. No output drives a pin high.
- R6: A frame whose count of shifted bits is not exactly 11 (for example 0, 10 or 12) is discarded, and no bank changes.
- R7: All 64 channels may be on at once. No limit on simultaneous active channels exists.
- R8: Asserting `rst_n` low clears every bank at once, so every pin is pulled low. The clear does not wait for a clock edge.
- R9: A rising edge of `ser_clk` while `ser_stb` is high is not shifted or counted. This includes an edge that reaches the block in the same cycle as the strobe rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_clk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_stb | input | 1 | Frame strobe; low while shifting, rising edge commits |
| pin_pull_low | output | 64 | Per-channel open-drain enable; 1 pulls the pin to ground |
| bank_state | output | 64 | Commanded on/off state of every channel |

## Verification
Two functions can land in the same system cycle: shifting a serial bit and committing the frame on the strobe rise. The bench provokes this by sending a complete 11-bit frame and then raising `ser_clk` and `ser_stb` at the same instant, with an extra data bit on the line. The frame must still commit as sent. If the extra edge were shifted, the bit count would reach 12 and the frame would be dropped, or the data would be displaced. Either way the bank readback shows it. Stray clock edges while the strobe idles high are also sent before a valid frame. The frame must then still land in the right bank.

// File: rtl/relay_pkg.sv
package relay_pkg;
  // index of each serial wire in the synchronizer vector
  localparam int unsigned SIG_SCLK = 0;
  localparam int unsigned SIG_SDAT = 1;
  localparam int unsigned SIG_STB  = 2;
  localparam int unsigned SIG_NUM  = 3;
endpackage

// File: rtl/relay_in_sync.sv
module relay_in_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];
  logic [WIDTH-1:0] prev_q, prev_d;

  always_comb begin
    stg_d[0] = async_in;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
    prev_d = stg_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      prev_q <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
      prev_q <= prev_d;
    end
  end

  assign lvl  = stg_q[STAGES-1];
  assign rise = stg_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/relay_frame_rx.sv
module relay_frame_rx #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sdat_lvl,
  input  logic              stb_lvl,
  input  logic              stb_rise,
  output logic              commit,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);
  localparam int unsigned FRAME_LEN = ADDR_W + DATA_W;
  localparam int unsigned CNT_MAX   = FRAME_LEN + 1;
  localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);

  logic [FRAME_LEN-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 shift_en;

  // a bit is taken only while the strobe is low
  assign shift_en = sclk_rise & ~stb_lvl;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (stb_rise) begin
      cnt_d = '0;
    end else if (shift_en) begin
      sr_d = {sr_q[FRAME_LEN-2:0], sdat_lvl};
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign commit   = stb_rise & (cnt_q == CNT_W'(FRAME_LEN));
  assign cmd_addr = sr_q[FRAME_LEN-1:DATA_W];
  assign cmd_data = sr_q[DATA_W-1:0];

  // R6: a strobe rise restarts the bit count for the next frame
  p_cnt_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rise |=> (cnt_q == '0));
  // R9: while the strobe is high the holding register does not move
  p_no_shift_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stb_lvl |=> $stable(sr_q));
  // R6: the count never runs past its saturation value
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CNT_MAX));
endmodule

// File: rtl/relay_bank_regs.sv
module relay_bank_regs #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned BANK_W    = 8,
  parameter int unsigned ADDR_W    = $clog2(NUM_BANKS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        commit,
  input  logic [ADDR_W-1:0]           cmd_addr,
  input  logic [BANK_W-1:0]           cmd_data,
  output logic [NUM_BANKS*BANK_W-1:0] state
);
  logic [NUM_BANKS-1:0] wr_en;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] bank_q, bank_d;

    assign wr_en[b] = commit & (cmd_addr == ADDR_W'(b));

    always_comb begin
      bank_d = bank_q;
      if (wr_en[b]) bank_d = cmd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q <= '0;
      else        bank_q <= bank_d;
    end

    assign state[b*BANK_W +: BANK_W] = bank_q;
  end

  // R4: never more than one bank written per cycle
  p_one_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
  // R3: without a commit no channel state changes
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(state));
  // R4: a commit changes at most BANK_W channel bits
  p_change_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> ($countones(state ^ $past(state)) <= BANK_W));
endmodule

// File: rtl/relay_bank_ctrl.sv
module relay_bank_ctrl #(
  parameter int unsigned NUM_BANKS   = 8,
  parameter int unsigned BANK_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ser_clk,
  input  logic                        ser_dat,
  input  logic                        ser_stb,
  output logic [NUM_BANKS*BANK_W-1:0] pin_pull_low,
  output logic [NUM_BANKS*BANK_W-1:0] bank_state
);
  import relay_pkg::*;

  localparam int unsigned ADDR_W = $clog2(NUM_BANKS);
  localparam int unsigned CH_NUM = NUM_BANKS * BANK_W;

  // asynchronous assert, synchronous release
  logic rst_meta_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  logic [SIG_NUM-1:0] ser_raw, ser_lvl, ser_rise;
  assign ser_raw[SIG_SCLK] = ser_clk;
  assign ser_raw[SIG_SDAT] = ser_dat;
  assign ser_raw[SIG_STB]  = ser_stb;

  relay_in_sync #(.WIDTH(SIG_NUM), .STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .async_in (ser_raw),
    .lvl      (ser_lvl),
    .rise     (ser_rise)
  );

  logic              commit;
  logic [ADDR_W-1:0] cmd_addr;
  logic [BANK_W-1:0] cmd_data;

  relay_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(BANK_W)) i_rx (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sclk_rise (ser_rise[SIG_SCLK]),
    .sdat_lvl  (ser_lvl[SIG_SDAT]),
    .stb_lvl   (ser_lvl[SIG_STB]),
    .stb_rise  (ser_rise[SIG_STB]),
    .commit    (commit),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data)
  );

  logic [CH_NUM-1:0] state;

  relay_bank_regs #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) i_banks (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .commit   (commit),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data),
    .state    (state)
  );

  // on = release the pin, off = pull it to ground
  assign pin_pull_low = ~state;
  assign bank_state   = state;

  // R8: while reset is held every pin is pulled low
  p_reset_pull_r8: assert property (@(posedge clk)
    !rst_n |-> (&pin_pull_low));
  // R3: channel state only moves in the cycle after a strobe rise
  p_commit_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    !ser_rise[SIG_STB] |=> $stable(bank_state));
endmodule

// File: tb/test_relay_bank_ctrl.sv
module test_relay_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_dat = 1'b0;
  logic        ser_stb = 1'b1;
  logic [63:0] pin_pull_low;
  logic [63:0] bank_state;

  int total = 0;
  int bad   = 0;
  logic [63:0] model = '0;

  always #10 clk = ~clk;

  relay_bank_ctrl i_relay_bank_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_clk      (ser_clk),
    .ser_dat      (ser_dat),
    .ser_stb      (ser_stb),
    .pin_pull_low (pin_pull_low),
    .bank_state   (bank_state)
  );

  // addr, data, number of bits shifted
  typedef struct packed {
    logic [2:0] addr;
    logic [7:0] data;
    logic [3:0] nbits;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 8'hA5, 4'd11},
    '{3'd7, 8'h3C, 4'd11},
    '{3'd3, 8'hFF, 4'd11},
    '{3'd3, 8'h00, 4'd10},
    '{3'd5, 8'h81, 4'd12},
    '{3'd5, 8'h81, 4'd11},
    '{3'd0, 8'h5A, 4'd11},
    '{3'd2, 8'h01, 4'd0},
    '{3'd1, 8'h80, 4'd11},
    '{3'd6, 8'h7E, 4'd11},
    '{3'd4, 8'hC3, 4'd11}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic check_pins(input string tag);
    check({tag, " state"}, bank_state, model);
    check({tag, " pins"}, pin_pull_low, ~model);
  endtask

  task automatic shift_bits(input logic [2:0] a, input logic [7:0] d, input int n);
    logic [10:0] seq;
    seq = {a, d};
    ser_stb = 1'b0;
    wait_clk(4);
    for (int i = 0; i < n; i++) begin
      ser_dat = (i < 11) ? seq[10-i] : 1'b0;
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
    end
    wait_clk(4);
  endtask

  task automatic end_frame();
    ser_stb = 1'b1;
    wait_clk(4);   // R3: result due within 4 cycles
  endtask

  task automatic send(input logic [2:0] a, input logic [7:0] d, input int n);
    shift_bits(a, d, n);
    end_frame();
    if (n == 11) model[a*8 +: 8] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_clk(3);
    // R8: outputs cleared while reset is held
    check_pins("R8 reset");
    rst_n = 1'b1;
    wait_clk(6);
    check_pins("R8 after release");

    // R1 R2 R4 R5 R6: table walk
    for (int v = 0; v < NVEC; v++) begin
      send(VECS[v].addr, VECS[v].data, int'(VECS[v].nbits));
      if (VECS[v].nbits != 4'd11) check_pins("R6 discarded frame");
      else check_pins("R1 R2 R4 R5 frame");
    end

    // R3: nothing changes before the strobe rises
    shift_bits(3'd2, 8'h99, 11);
    check_pins("R3 before strobe");
    end_frame();
    model[2*8 +: 8] = 8'h99;
    check_pins("R3 after strobe");

    // R7: every channel on at once
    for (int b = 0; b < 8; b++) send(3'(b), 8'hFF, 11);
    check("R7 all on state", bank_state, {64{1'b1}});
    check("R7 all released", pin_pull_low, 64'h0);

    // R9: stray clock edges while strobe idles high
    for (int k = 0; k < 3; k++) begin
      ser_dat = 1'b1;
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
    end
    send(3'd4, 8'h12, 11);
    check_pins("R9 stray edges ignored");

    // R9: clock edge in the same cycle as the strobe rise
    shift_bits(3'd6, 8'h0F, 11);
    ser_dat = 1'b1;
    wait_clk(4);
    ser_clk = 1'b1;
    ser_stb = 1'b1;
    wait_clk(4);
    ser_clk = 1'b0;
    model[6*8 +: 8] = 8'h0F;
    check_pins("R9 collision");

    // R8: asynchronous clear mid-run
    @(posedge clk);
    #3 rst_n = 1'b0;
    #2;
    model = '0;
    check_pins("R8 async clear");
    wait_clk(2);
    rst_n = 1'b1;
    wait_clk(4);
    send(3'd1, 8'h42, 11);
    check_pins("R1 after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule